// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block decides when a DRAM controller must spend time on refresh. A free-running interval timer adds one owed refresh each time it expires. The owed refreshes are paid back while the controller reports that it is idle. Each payment has three steps. First the block asks for every bank to be closed. Once the controller confirms, the block raises a refresh request and waits for a grant. After the grant it holds a command-blocking window open for the refresh recovery time.

Up to eight refreshes may be owed at once. When the eighth is owed, an urgent flag rises. While urgent, the block ignores the busy flag and drains the whole debt back to back.

The same handshake also puts the memory into self refresh. The clock-enable output is low for the whole stay. During the stay the interval timer stands still and the debt is cleared. On exit, the block opens two windows: a short one that holds off every command, and a long one that holds off only reads.

Top module: `refresh_sched`

## Requirements
- R1: One refresh becomes owed each time INTERVAL_CLKS clocks pass outside self refresh. The first one is owed at the INTERVAL_CLKS-th rising edge after reset is released.
- R2: The owed count saturates at MAX_OWED (8). A refresh is started from idle only when the count is non-zero and `ctrl_busy` is low, unless R4 applies.
- R3: Each refresh and each self-refresh entry begins with `pre_all_req` held high until `pre_done` is seen. `ref_req` rises only in the cycle after `pre_all_req` was high, and the two outputs are never high together.
- R4: `ref_urgent` rises on the same edge that the owed count reaches 8. It stays high until the count is back at 0. While it is high, refreshes start and follow one another regardless of `ctrl_busy`, and they take priority over a self-refresh entry request.
- R5: A grant of a normal refresh (`ref_req`=1, `ref_sr`=0) lowers the owed count by one. It also raises `blk_cmd` and `blk_rd` for exactly ceil(TRFC_NS*CLK_MHZ/1000) clocks, which is 10 with the default values.
- R6: When `sr_enter_req` is seen in idle with no urgent debt, the block precharges and then raises `ref_req` together with `ref_sr`=1. The grant of that request drives `cke_out` low and `sr_active` high on the same edge.
- R7: While `sr_active` is high, the interval timer is frozen, the owed count is 0, no refresh is requested, and `blk_cmd` and `blk_rd` are both held high.
- R8: `sr_exit_req` seen during self refresh sets `cke_out` high on the next edge. It then keeps `blk_cmd` high for ceil(TXSNR_NS*CLK_MHZ/1000) clocks (10) and `blk_rd` high for TXSRD_CLKS clocks (200). A refresh grant that comes later never shortens a window that is still open.
- R9: During reset all request, urgent and blocking outputs are low, and `cke_out` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_busy | input | 1 | Controller has traffic; defers non-urgent refresh |
| pre_done | input | 1 | All banks are closed; answers `pre_all_req` |
| ref_grant | input | 1 | Controller issues the requested refresh this cycle |
| sr_enter_req | input | 1 | Level request to enter self refresh |
| sr_exit_req | input | 1 | Level request to leave self refresh |
| pre_all_req | output | 1 | Ask the controller to close all banks |
| ref_req | output | 1 | Refresh command requested |
| ref_sr | output | 1 | The pending `ref_req` is a self-refresh entry |
| ref_urgent | output | 1 | Owed count hit the limit; busy is ignored |
| blk_cmd | output | 1 | No command of any kind may be issued |
| blk_rd | output | 1 | No read command may be issued |
| cke_out | output | 1 | Clock enable toward the memory |
| sr_active | output | 1 | Memory is in self refresh |

## Verification
The assertions assume that the controller follows the handshake. `pre_done` is raised only while `pre_all_req` is high, and `ref_grant` only while `ref_req` is high. They also assume that the read window is configured no shorter than the non-read exit window. The bench drives both answers from one responder that looks at the outputs at the falling edge. It lets the answer latency vary, and can hold grants back entirely to drive the debt into saturation. Busy is kept high across the self-refresh exit, so that the exit windows can be measured without a refresh grant landing inside them.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_REQ, ST_RFC, ST_SPRE, ST_SREQ, ST_SR, ST_XIT
  } sched_st_t;

  // nanoseconds to whole clocks, rounded up
  function automatic int unsigned ns_to_clks(input int unsigned ns,
                                             input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  // a window reload never shortens an open window
  function automatic int unsigned keep_longer(input int unsigned cur,
                                              input int unsigned val);
    return (cur > val) ? cur : val;
  endfunction

  // owed-count update with saturation at cap
  function automatic int unsigned owed_next(input int unsigned cur,
                                            input logic inc,
                                            input logic dec,
                                            input int unsigned cap);
    int unsigned t;
    t = cur + (inc ? 1 : 0);
    if (dec && t != 0) t = t - 1;
    return (t > cap) ? cap : t;
  endfunction

endpackage

// File: rtl/refsch_interval.sv
module refsch_interval #(
  parameter int unsigned INTERVAL_CLKS = 1040
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze,
  output logic tick
);
  localparam int unsigned CW = $clog2(INTERVAL_CLKS);
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL_CLKS - 1);

  logic [CW-1:0] cnt_q;

  assign tick = !freeze && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= RELOAD;
    else if (!freeze) cnt_q <= (cnt_q == '0) ? RELOAD : cnt_q - 1'b1;
  end

  AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    freeze && $past(freeze) && $past(rst_n) |-> $stable(cnt_q)); // R7
endmodule

// File: rtl/refsch_debt.sv
module refsch_debt import refsch_pkg::*; #(
  parameter int unsigned MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic dec,
  input  logic clr,
  output logic owed_nz,
  output logic urgent
);
  localparam int unsigned DW = $clog2(MAX_OWED + 1);

  logic [DW-1:0] owed_q, owed_d;
  logic          urg_q;

  always_comb begin
    if (clr) owed_d = '0;
    else     owed_d = DW'(owed_next(32'(owed_q), tick, dec, MAX_OWED));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed_q <= '0;
      urg_q  <= 1'b0;
    end else begin
      owed_q <= owed_d;
      if (owed_d == DW'(MAX_OWED)) urg_q <= 1'b1;
      else if (owed_d == '0)       urg_q <= 1'b0;
    end
  end

  assign owed_nz = (owed_q != '0);
  assign urgent  = urg_q;

  AST_OWED_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= DW'(MAX_OWED)); // R2
  AST_URGENT_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(urg_q) |-> owed_q == DW'(MAX_OWED)); // R4
  AST_URGENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(urg_q) |-> owed_q == '0); // R4
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> owed_q == '0); // R7
endmodule

// File: rtl/refsch_window.sv
module refsch_window import refsch_pkg::*; #(
  parameter int unsigned TRFC_CLKS  = 10,
  parameter int unsigned TXSNR_CLKS = 10,
  parameter int unsigned TXSRD_CLKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_rfc,
  input  logic load_exit,
  output logic nr_busy,
  output logic rd_busy
);
  localparam int unsigned MAXW = keep_longer(keep_longer(TRFC_CLKS, TXSNR_CLKS), TXSRD_CLKS);
  localparam int unsigned WW   = $clog2(MAXW + 1);

  logic [WW-1:0] nr_q, rd_q, nr_d, rd_d;

  always_comb begin
    nr_d = (nr_q != '0) ? nr_q - 1'b1 : nr_q;
    rd_d = (rd_q != '0) ? rd_q - 1'b1 : rd_q;
    if (load_rfc) begin
      nr_d = WW'(keep_longer(32'(nr_q), TRFC_CLKS));
      rd_d = WW'(keep_longer(32'(rd_q), TRFC_CLKS));
    end else if (load_exit) begin
      nr_d = WW'(keep_longer(32'(nr_q), TXSNR_CLKS));
      rd_d = WW'(keep_longer(32'(rd_q), TXSRD_CLKS));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nr_q <= '0;
      rd_q <= '0;
    end else begin
      nr_q <= nr_d;
      rd_q <= rd_d;
    end
  end

  assign nr_busy = (nr_q != '0);
  assign rd_busy = (rd_q != '0);

  // read window is configured no shorter than the non-read one
  AST_RD_COVERS_NR: assert property (@(posedge clk) disable iff (!rst_n)
    nr_busy |-> rd_busy); // R8
  AST_EXIT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    load_exit |=> nr_busy && rd_busy); // R8
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched import refsch_pkg::*; #(
  parameter int unsigned INTERVAL_CLKS = 1040,
  parameter int unsigned MAX_OWED      = 8,
  parameter int unsigned CLK_MHZ       = 133,
  parameter int unsigned TRFC_NS       = 75,
  parameter int unsigned TXSNR_NS      = 75,
  parameter int unsigned TXSRD_CLKS    = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_busy,
  input  logic pre_done,
  input  logic ref_grant,
  input  logic sr_enter_req,
  input  logic sr_exit_req,
  output logic pre_all_req,
  output logic ref_req,
  output logic ref_sr,
  output logic ref_urgent,
  output logic blk_cmd,
  output logic blk_rd,
  output logic cke_out,
  output logic sr_active
);
  localparam int unsigned TRFC_CLKS  = ns_to_clks(TRFC_NS, CLK_MHZ);
  localparam int unsigned TXSNR_CLKS = ns_to_clks(TXSNR_NS, CLK_MHZ);

  sched_st_t st_q, st_d;

  logic tick, owed_nz, urgent, win_nr, win_rd;
  logic in_sr, ev_ref_done, ev_sr_enter, ev_sr_exit;

  // named internal events
  assign in_sr       = (st_q == ST_SR);
  assign ev_ref_done = (st_q == ST_REQ)  && ref_grant;
  assign ev_sr_enter = (st_q == ST_SREQ) && ref_grant;
  assign ev_sr_exit  = in_sr && sr_exit_req;

  refsch_interval #(.INTERVAL_CLKS(INTERVAL_CLKS)) u_interval (
    .clk(clk), .rst_n(rst_n), .freeze(in_sr), .tick(tick));

  refsch_debt #(.MAX_OWED(MAX_OWED)) u_debt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dec(ev_ref_done),
    .clr(in_sr || ev_sr_enter), .owed_nz(owed_nz), .urgent(urgent));

  refsch_window #(.TRFC_CLKS(TRFC_CLKS), .TXSNR_CLKS(TXSNR_CLKS),
                  .TXSRD_CLKS(TXSRD_CLKS)) u_window (
    .clk(clk), .rst_n(rst_n), .load_rfc(ev_ref_done), .load_exit(ev_sr_exit),
    .nr_busy(win_nr), .rd_busy(win_rd));

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (urgent)                       st_d = ST_PRE;
        else if (sr_enter_req)            st_d = ST_SPRE;
        else if (owed_nz && !ctrl_busy)   st_d = ST_PRE;
      end
      ST_PRE:  if (pre_done)    st_d = ST_REQ;
      ST_REQ:  if (ref_grant)   st_d = ST_RFC;
      ST_RFC:  if (!win_nr)     st_d = ST_IDLE;
      ST_SPRE: if (pre_done)    st_d = ST_SREQ;
      ST_SREQ: if (ref_grant)   st_d = ST_SR;
      ST_SR:   if (sr_exit_req) st_d = ST_XIT;
      ST_XIT:  if (!win_nr)     st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign pre_all_req = (st_q == ST_PRE) || (st_q == ST_SPRE);
  assign ref_req     = (st_q == ST_REQ) || (st_q == ST_SREQ);
  assign ref_sr      = (st_q == ST_SREQ);
  assign ref_urgent  = urgent;
  assign blk_cmd     = win_nr || in_sr;
  assign blk_rd      = win_rd || in_sr;
  assign cke_out     = !in_sr;
  assign sr_active   = in_sr;

  AST_REQ_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_req) |-> $past(pre_all_req)); // R3
  AST_RFC_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req && !ref_sr && ref_grant |=> blk_cmd && blk_rd); // R5
  AST_CKE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke_out) |-> $past(ref_req && ref_sr && ref_grant)); // R6
  AST_SR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> !ref_req && !pre_all_req && !ref_urgent); // R7
  AST_EXIT_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active && sr_exit_req |=> cke_out && blk_cmd); // R8
endmodule

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
  localparam int IV     = 60;   // interval used by the bench
  localparam int CAP    = 8;    // R2
  localparam int T_RFC  = 10;   // R5: ceil(75*133/1000)
  localparam int T_XSNR = 10;   // R8
  localparam int T_XSRD = 200;  // R8

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_busy = 1'b0, pre_done = 1'b0, ref_grant = 1'b0;
  logic sr_enter_req = 1'b0, sr_exit_req = 1'b0;
  logic pre_all_req, ref_req, ref_sr, ref_urgent, blk_cmd, blk_rd, cke_out, sr_active;

  refresh_sched #(.INTERVAL_CLKS(IV)) uut (
    .clk(clk), .rst_n(rst_n), .ctrl_busy(ctrl_busy), .pre_done(pre_done),
    .ref_grant(ref_grant), .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req),
    .pre_all_req(pre_all_req), .ref_req(ref_req), .ref_sr(ref_sr),
    .ref_urgent(ref_urgent), .blk_cmd(blk_cmd), .blk_rd(blk_rd),
    .cke_out(cke_out), .sr_active(sr_active));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference: modes as strings-free integers
  // mode: idle, closing banks, asking, recovering, sr closing, sr asking, in sr, leaving
  typedef enum int {M_IDLE, M_CLOSE, M_ASK, M_REC, M_SCLOSE, M_SASK, M_IN, M_LEAVE} mode_t;
  mode_t md = M_IDLE;
  int left = IV - 1, owed = 0, urg = 0, win_a = 0, win_r = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      md = M_IDLE; left = IV - 1; owed = 0; urg = 0; win_a = 0; win_r = 0;
    end else begin
      cyc++;
      begin
        bit expire, paid, enter, leave;
        mode_t nm;
        expire = (md != M_IN) && left == 0;
        paid   = (md == M_ASK) && ref_grant;
        enter  = (md == M_SASK) && ref_grant;
        leave  = (md == M_IN) && sr_exit_req;
        nm = md;
        if (md == M_IDLE) begin
          if (urg) nm = M_CLOSE;
          else if (sr_enter_req) nm = M_SCLOSE;
          else if (owed > 0 && !ctrl_busy) nm = M_CLOSE;
        end
        else if (md == M_CLOSE  && pre_done) nm = M_ASK;
        else if (md == M_ASK    && ref_grant) nm = M_REC;
        else if (md == M_REC    && win_a == 0) nm = M_IDLE;
        else if (md == M_SCLOSE && pre_done) nm = M_SASK;
        else if (md == M_SASK   && ref_grant) nm = M_IN;
        else if (md == M_IN     && sr_exit_req) nm = M_LEAVE;
        else if (md == M_LEAVE  && win_a == 0) nm = M_IDLE;
        if (md != M_IN) left = (left == 0) ? IV - 1 : left - 1;
        if (md == M_IN || enter) owed = 0;
        else begin
          if (expire && owed < CAP) owed++;
          else if (expire && paid) owed++;
          if (paid) owed--;
        end
        if (owed == CAP) urg = 1; else if (owed == 0) urg = 0;
        if (paid) begin
          win_a = (win_a > T_RFC) ? win_a : T_RFC;
          win_r = (win_r > T_RFC) ? win_r : T_RFC;
        end else if (leave) begin
          win_a = (win_a > T_XSNR) ? win_a : T_XSNR;
          win_r = (win_r > T_XSRD) ? win_r : T_XSRD;
        end else begin
          if (win_a > 0) win_a--;
          if (win_r > 0) win_r--;
        end
        md = nm;
      end
    end
  end

  // responder and per-cycle compare
  int pre_lat = 2, gnt_lat = 1, pw = 0, gw = 0;
  bit gnt_en = 1;
  int run_a = 0, run_r = 0, kind = 0; // kind 1: windows come from a self-refresh exit
  always @(negedge clk) begin
    if (rst_n) begin
      check("R3 pre_all_req", pre_all_req, (md == M_CLOSE || md == M_SCLOSE));
      check("R2 ref_req",     ref_req,     (md == M_ASK || md == M_SASK));
      check("R6 ref_sr",      ref_sr,      (md == M_SASK));
      check("R4 ref_urgent",  ref_urgent,  urg);
      check("R5 blk_cmd",     blk_cmd,     (win_a != 0 || md == M_IN));
      check("R8 blk_rd",      blk_rd,      (win_r != 0 || md == M_IN));
      check("R6 cke_out",     cke_out,     (md != M_IN));
      check("R7 sr_active",   sr_active,   (md == M_IN));
      if (sr_active) begin run_a = 0; run_r = 0; kind = 1; end
      else begin
        if (blk_cmd) run_a++;
        else if (run_a > 0) begin
          check(kind ? "R8 non-read exit window" : "R5 recovery window", run_a, kind ? T_XSNR : T_RFC);
          run_a = 0;
        end
        if (blk_rd) run_r++;
        else if (run_r > 0) begin
          check(kind ? "R8 read exit window" : "R5 read recovery window", run_r, kind ? T_XSRD : T_RFC);
          run_r = 0; kind = 0;
        end
      end
    end
    if (pre_all_req) begin pw++; pre_done = (pw >= pre_lat); end
    else begin pw = 0; pre_done = 0; end
    if (ref_req && gnt_en) begin gw++; ref_grant = (gw >= gnt_lat); end
    else begin gw = 0; ref_grant = 0; end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  int first_urg, waited;
  bit req_early;
  initial begin
    ctrl_busy = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset values
    check("R9 pre_all_req", pre_all_req, 0);
    check("R9 ref_req", ref_req, 0);
    check("R9 ref_urgent", ref_urgent, 0);
    check("R9 blk_cmd", blk_cmd, 0);
    check("R9 blk_rd", blk_rd, 0);
    check("R9 cke_out", cke_out, 1);
    check("R9 sr_active", sr_active, 0);
    rst_n = 1'b1;

    // R1/R4: busy held, debt builds to the cap
    first_urg = -1; req_early = 0;
    while (first_urg < 0 && cyc < 2000) begin
      @(negedge clk);
      if (ref_urgent) first_urg = cyc;
      else if (ref_req) req_early = 1;
    end
    check("R1 first urgent edge", first_urg, CAP * IV);
    check("R2 busy defers refresh", req_early, 0);
    // R4: drained although busy stays high
    waited = 0;
    while (ref_urgent && waited < 3000) begin @(negedge clk); waited++; end
    check("R4 urgent clears with busy high", ref_urgent, 0);

    // normal traffic with slower answers
    ctrl_busy = 1'b0; pre_lat = 4; gnt_lat = 3;
    repeat (400) @(negedge clk);

    // R2 saturation: grants withheld
    ctrl_busy = 1'b1; gnt_en = 0;
    repeat (12 * IV) @(negedge clk);
    check("R2 request held while grant withheld", ref_req, 1);
    gnt_en = 1;
    waited = 0;
    while (ref_urgent && waited < 3000) begin @(negedge clk); waited++; end
    check("R4 urgent drained after saturation", ref_urgent, 0);

    // R6: self-refresh entry
    repeat (20) @(negedge clk);
    sr_enter_req = 1'b1;
    waited = 0;
    while (!sr_active && waited < 500) begin @(negedge clk); waited++; end
    sr_enter_req = 1'b0;
    check("R6 entered self refresh", sr_active, 1);
    check("R6 cke low in self refresh", cke_out, 0);
    // R7: long stay, nothing requested
    repeat (5 * IV) @(negedge clk);
    check("R7 no request in self refresh", ref_req, 0);
    check("R7 commands blocked in self refresh", blk_cmd, 1);
    // R8: exit
    sr_exit_req = 1'b1;
    @(negedge clk);
    sr_exit_req = 1'b0;
    check("R8 cke high after exit", cke_out, 1);
    check("R8 reads blocked after exit", blk_rd, 1);
    repeat (260) @(negedge clk);
    ctrl_busy = 1'b0; pre_lat = 1; gnt_lat = 1;
    repeat (500) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule